// File: doc/BRIEF.md
# Strobe Pulse Clock-Domain Synchronizer

This block moves one-cycle strobe pulses from a source clock domain into a destination clock domain that runs on an unrelated clock. Each strobe the block accepts comes out as exactly one pulse, one destination cycle wide. There are several independent channels, and each channel handles one pulse at a time.

Inside each channel, an accepted strobe flips a toggle level. A two-flop chain carries that level to the destination side, which edge-detects it and emits the pulse. The destination's record of the level then returns through a second two-flop chain as an acknowledge. A channel's busy output stays high until that acknowledge matches its toggle. A strobe that arrives while busy is high is ignored, so a transfer in flight cannot be corrupted. Upstream logic is expected to watch busy and hold new strobes back. Both resets are active-low and asynchronous, and each must be released synchronously to its own clock.

Top module: `strobe_cdc_sync`

## Requirements
- R1: A source strobe sampled high on a source clock edge while that channel's busy is low is accepted, and busy reads high from that edge onward.
- R2: Each accepted strobe produces exactly one destination pulse, high for a single destination clock cycle.
- R3: Busy returns low only after the destination pulse for the accepted strobe has been produced.
- R4: With the default of two synchronizer stages, the destination pulse is high after the third destination clock edge that follows the accepting source edge.
- R5: A strobe that arrives while busy is high is ignored: it produces no destination pulse and does not change busy.
- R6: While its reset is asserted, each domain holds its outputs low (busy low, destination pulses low). No pulse appears after reset is released until a strobe is accepted.
- R7: Channels are independent: each channel's pulse count matches only that channel's accepted strobes.
- R8: A strobe held high continuously is accepted again on the first source edge at which busy is low. This gives back-to-back transfers, each delivered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous assert |
| src_strobe | input | CHANNELS | Strobe request per channel, source domain |
| src_busy | output | CHANNELS | Transfer in flight per channel, source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous assert |
| dst_strobe | output | CHANNELS | Regenerated one-cycle pulse per channel, destination domain |

## Verification
The case that needs care is a new strobe landing in the first source cycle after the returning acknowledge has cleared busy. On that edge, the end of one handshake and the start of the next are decided together. The bench provokes this by holding a channel's strobe high without a break, and also with dense pseudo-random strobes, using a source clock both faster and much slower than the destination clock. A behavioural model counts only the strobes it sees land while busy is low. The bench judges the case by requiring that the destination pulse count match that count exactly, and that no destination pulse ever run into a second cycle.

// File: rtl/strobe_cdc_pkg.sv
package strobe_cdc_pkg;
  // Minimum number of flops in any crossing chain.
  localparam int unsigned SYNC_STAGES_MIN = 2;

  // Clamp a requested chain depth to the legal minimum.
  function automatic int unsigned legal_stages(input int unsigned req);
    return (req < SYNC_STAGES_MIN) ? SYNC_STAGES_MIN : req;
  endfunction
endpackage

// File: rtl/strobe_cdc_chain.sv
module strobe_cdc_chain #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_d,
  output logic [WIDTH-1:0] sync_q
);
  logic [WIDTH-1:0] stg_d [STAGES];
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = async_d;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[s] <= '0;
      end else begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  assign sync_q = stg_q[STAGES-1];
endmodule

// File: rtl/strobe_cdc_src.sv
module strobe_cdc_src #(
  parameter int unsigned CHANNELS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] strobe,
  input  logic [CHANNELS-1:0] ack_sync,
  output logic [CHANNELS-1:0] toggle,
  output logic [CHANNELS-1:0] busy
);
  logic [CHANNELS-1:0] tog_q;
  logic [CHANNELS-1:0] tog_d;
  logic [CHANNELS-1:0] take;
  logic [CHANNELS-1:0] busy_c;

  // Next state: a strobe is taken only when no transfer is pending.
  always_comb begin
    busy_c = tog_q ^ ack_sync;
    take   = strobe & ~busy_c;
    tog_d  = ~tog_q;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tog_q[c] <= 1'b0;
      end else if (take[c]) begin
        tog_q[c] <= tog_d[c];
      end
    end
  end

  assign toggle = tog_q;
  assign busy   = busy_c;
endmodule

// File: rtl/strobe_cdc_dst.sv
module strobe_cdc_dst #(
  parameter int unsigned CHANNELS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] toggle_sync,
  output logic [CHANNELS-1:0] seen,
  output logic [CHANNELS-1:0] pulse
);
  logic [CHANNELS-1:0] seen_q;
  logic [CHANNELS-1:0] seen_d;
  logic [CHANNELS-1:0] chg;
  logic [CHANNELS-1:0] pulse_q;
  logic [CHANNELS-1:0] pulse_d;

  always_comb begin
    chg     = toggle_sync ^ seen_q;
    seen_d  = toggle_sync;
    pulse_d = chg;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q[c] <= 1'b0;
      end else if (chg[c]) begin
        seen_q[c] <= seen_d[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign seen  = seen_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/strobe_cdc_sync.sv
module strobe_cdc_sync #(
  parameter int unsigned CHANNELS    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                src_clk,
  input  logic                src_rst_n,
  input  logic [CHANNELS-1:0] src_strobe,
  output logic [CHANNELS-1:0] src_busy,
  input  logic                dst_clk,
  input  logic                dst_rst_n,
  output logic [CHANNELS-1:0] dst_strobe
);
  import strobe_cdc_pkg::*;

  localparam int unsigned STG = legal_stages(SYNC_STAGES);

  logic [CHANNELS-1:0] src_toggle;
  logic [CHANNELS-1:0] toggle_at_dst;
  logic [CHANNELS-1:0] dst_seen;
  logic [CHANNELS-1:0] ack_at_src;

  strobe_cdc_src #(.CHANNELS(CHANNELS)) u_src (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .strobe   (src_strobe),
    .ack_sync (ack_at_src),
    .toggle   (src_toggle),
    .busy     (src_busy)
  );

  strobe_cdc_chain #(.WIDTH(CHANNELS), .STAGES(STG)) u_fwd (
    .clk     (dst_clk),
    .rst_n   (dst_rst_n),
    .async_d (src_toggle),
    .sync_q  (toggle_at_dst)
  );

  strobe_cdc_dst #(.CHANNELS(CHANNELS)) u_dst (
    .clk         (dst_clk),
    .rst_n       (dst_rst_n),
    .toggle_sync (toggle_at_dst),
    .seen        (dst_seen),
    .pulse       (dst_strobe)
  );

  strobe_cdc_chain #(.WIDTH(CHANNELS), .STAGES(STG)) u_back (
    .clk     (src_clk),
    .rst_n   (src_rst_n),
    .async_d (dst_seen),
    .sync_q  (ack_at_src)
  );
endmodule

// File: rtl/strobe_cdc_checker.sv
module strobe_cdc_checker #(
  parameter int unsigned CHANNELS = 2
) (
  input logic                src_clk,
  input logic                src_rst_n,
  input logic [CHANNELS-1:0] src_strobe,
  input logic [CHANNELS-1:0] src_busy,
  input logic                dst_clk,
  input logic                dst_rst_n,
  input logic [CHANNELS-1:0] dst_strobe
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
    assert_accept_sets_busy_R1: assert property (
      @(posedge src_clk) disable iff (!src_rst_n)
      (src_strobe[c] && !src_busy[c]) |=> src_busy[c]
    ) else $error("R1 busy not raised after accepted strobe, channel %0d", c);

    assert_single_cycle_pulse_R2: assert property (
      @(posedge dst_clk) disable iff (!dst_rst_n)
      dst_strobe[c] |=> !dst_strobe[c]
    ) else $error("R2 destination pulse longer than one cycle, channel %0d", c);

    assert_busy_needs_strobe_R5: assert property (
      @(posedge src_clk) disable iff (!src_rst_n)
      $rose(src_busy[c]) |-> $past(src_strobe[c])
    ) else $error("R5 busy rose without a strobe, channel %0d", c);

    assert_src_reset_idle_R6: assert property (
      @(posedge src_clk) !src_rst_n |-> !src_busy[c]
    ) else $error("R6 busy high in reset, channel %0d", c);

    assert_dst_reset_idle_R6: assert property (
      @(posedge dst_clk) !dst_rst_n |-> !dst_strobe[c]
    ) else $error("R6 pulse high in reset, channel %0d", c);
  end
endmodule

bind strobe_cdc_sync strobe_cdc_checker #(.CHANNELS(CHANNELS)) u_chk (
  .src_clk    (src_clk),
  .src_rst_n  (src_rst_n),
  .src_strobe (src_strobe),
  .src_busy   (src_busy),
  .dst_clk    (dst_clk),
  .dst_rst_n  (dst_rst_n),
  .dst_strobe (dst_strobe)
);

// File: tb/sim_strobe_cdc_sync.sv
`timescale 1ns/100ps
module sim_strobe_cdc_sync;
  localparam int CH = 2;

  realtime    src_half = 1.7;
  logic       src_clk = 1'b0;
  logic       dst_clk = 1'b0;
  logic       src_rst_n = 1'b0;
  logic       dst_rst_n = 1'b0;
  logic [CH-1:0] src_strobe = '0;
  logic [CH-1:0] src_busy;
  logic [CH-1:0] dst_strobe;

  always #(src_half) src_clk = ~src_clk;
  always #2.5 dst_clk = ~dst_clk;   // 200 MHz

  strobe_cdc_sync #(.CHANNELS(CH), .SYNC_STAGES(2)) u0 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_strobe(src_strobe),
    .src_busy(src_busy), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_strobe(dst_strobe)
  );

  int checks = 0;
  int errors = 0;
  int acc [CH];
  int outc [CH];
  int ignored [CH];
  bit was_acc [CH];
  bit prev_out [CH];
  realtime acc_t [CH][$];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Destination-side model: every pulse must match a pending accepted strobe.
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      for (int c = 0; c < CH; c++) begin
        if (dst_strobe[c]) begin
          outc[c]++;
          chk(!prev_out[c], "R2 pulse wider than one cycle", 1, 0);
          if (acc_t[c].size() == 0) begin
            chk(1'b0, "R2 R5 pulse with no accepted strobe", outc[c], acc[c]);
          end else begin
            realtime t0;
            t0 = acc_t[c].pop_front();
            chk(($realtime - t0) <= (src_half + 17.6), "R4 pulse latency",
                int'($realtime - t0), int'(src_half + 17.6));
          end
        end
        prev_out[c] = dst_strobe[c];
      end
    end
  end

  task automatic run_phase(input int m0, input int m1, input int n);
    int start [CH];
    for (int c = 0; c < CH; c++) start[c] = acc[c];
    for (int i = 0; i < n; i++) begin
      @(negedge src_clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      for (int c = 0; c < CH; c++) begin
        int md;
        bit s;
        md = (c == 0) ? m0 : m1;
        if (was_acc[c]) chk(src_busy[c] === 1'b1, "R1 busy after accept", src_busy[c], 1);
        was_acc[c] = 1'b0;
        if (src_busy[c] === 1'b0)
          chk(outc[c] == acc[c], "R3 busy low before delivery", outc[c], acc[c]);
        case (md)
          0: s = ((i % 37) == 0);
          1: s = 1'b1;
          2: s = lf[c*3];
          default: s = 1'b0;
        endcase
        src_strobe[c] = s;
        if (s && !src_busy[c]) begin
          acc[c]++;
          was_acc[c] = 1'b1;
          acc_t[c].push_back($realtime);
        end else if (s) begin
          ignored[c]++;
        end
      end
    end
    for (int c = 0; c < CH; c++) begin
      if (((c == 0) ? m0 : m1) == 1)
        chk((acc[c] - start[c]) > 1, "R8 back-to-back transfers", acc[c] - start[c], 2);
    end
  endtask

  task automatic drain();
    @(negedge src_clk);
    src_strobe = '0;
    for (int c = 0; c < CH; c++) was_acc[c] = 1'b0;
    for (int i = 0; i < 200 && src_busy != '0; i++) @(negedge src_clk);
    repeat (10) @(negedge dst_clk);
    chk(src_busy == '0, "R3 busy clears", src_busy, 0);
    for (int c = 0; c < CH; c++)
      chk(outc[c] == acc[c], "R2 R7 pulse count per channel", outc[c], acc[c]);
  endtask

  initial begin
    for (int c = 0; c < CH; c++) begin
      acc[c] = 0; outc[c] = 0; ignored[c] = 0; was_acc[c] = 0; prev_out[c] = 0;
    end
    repeat (4) @(negedge dst_clk);
    chk(src_busy == '0, "R6 busy in reset", src_busy, 0);
    chk(dst_strobe == '0, "R6 pulse in reset", dst_strobe, 0);
    @(negedge dst_clk) dst_rst_n = 1'b1;
    @(negedge src_clk) src_rst_n = 1'b1;
    repeat (30) @(negedge src_clk);
    chk(outc[0] + outc[1] == 0, "R6 no pulse after reset", outc[0] + outc[1], 0);
    chk(src_busy == '0, "R6 idle after reset", src_busy, 0);

    // fast source into slower destination
    run_phase(0, 2, 400);
    drain();
    run_phase(1, 0, 300);
    drain();
    // slow source into faster destination
    src_half = 8.3;
    repeat (3) @(negedge src_clk);
    run_phase(2, 1, 200);
    drain();
    run_phase(1, 2, 200);
    drain();

    chk(ignored[0] + ignored[1] > 0, "R5 strobes during busy seen",
        ignored[0] + ignored[1], 1);
    chk(acc[0] != acc[1], "R7 channels carried distinct traffic", acc[0], acc[1] + 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule